// File: doc/BRIEF.md
# I2C Command Framer for a Dual Wiper Controller

This block is the bus-facing half of a two-channel digital potentiometer controller. It watches a standard two-wire serial bus through a system clock, recognises START and STOP, and answers only when the address byte holds the fixed device identifier nibble `0101` followed by four strap pins. Once selected, it takes an instruction byte and frames the rest of the transaction from the opcode. For a write, the framer takes in one data byte. For a read, it shifts out a byte that the register executor supplies. A transfer is complete after the instruction byte alone. In step mode, each further SCL pulse moves one wiper by one tap.

The framer never touches wiper or stored values itself. It hands the executor a one-cycle command strobe with opcode, pot select, register select and data. It also sends a step strobe with a direction bit, and a strobe when a STOP closes a selected transaction. While the executor reports that a non-volatile write is still in progress, the framer does not acknowledge its address. A master can therefore poll with bare address bytes until it gets an ACK.

Top module: `potbus_framer`

## Requirements
- R1: After reset the SDA pull-down is released and no command, step or stop strobe is issued until a selected transaction occurs.
- R2: The address byte, sent MSB first, is acknowledged on the ninth clock only when it equals `0101` followed by `devAddr[3:0]`. Any other address byte gets no ACK, and the rest of that transaction is ignored: no ACK and no strobes until the next START.
- R3: If `execBusy` is high when the address byte completes, the address is not acknowledged and the transaction is ignored.
- R4: The instruction byte carries the opcode in bits 7:4, the pot select in bit 2 and the register select in bits 1:0. Opcodes `1010` and `1100` are writes: the next byte is acknowledged and `cmdValid` pulses once, with `cmdData` equal to that byte.
- R5: Opcodes `1101`, `1110`, `0001` and `1000` are transfers: `cmdValid` pulses once after the instruction byte, and any further byte before STOP is not acknowledged.
- R6: Opcodes `1001` and `1011` are reads: starting right after the instruction ACK, the framer shifts out `rdData` MSB first. It sends another byte each time the master acknowledges. After a master NACK it drives nothing more, so further clocks read all ones. A read never pulses `cmdValid`.
- R7: Opcode `0010` enters step mode: every later SCL rising edge pulses `stepValid`, with `stepUp` equal to the SDA level, until START or STOP.
- R8: A STOP that ends a selected transaction pulses `stopStrobe` once. A STOP after an unselected or ignored address does not.
- R9: A START in the middle of a transaction abandons the pending command without a strobe and restarts address reception.
- R10: Any other opcode is acknowledged as an instruction byte but produces no command, and later bytes are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| devAddr | input | 4 | Strap pins forming the low address nibble |
| execBusy | input | 1 | Executor busy with a non-volatile write |
| rdData | input | 8 | Byte to return for the current read command |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| cmdValid | output | 1 | One-cycle strobe: a write or transfer command is ready |
| cmdOp | output | 4 | Latched opcode |
| cmdPot | output | 1 | Latched pot select |
| cmdReg | output | 2 | Latched register select |
| cmdData | output | 8 | Data byte of the last write command |
| stepValid | output | 1 | One-cycle strobe: move the selected wiper one tap |
| stepUp | output | 1 | Step direction, 1 toward the high end |
| stopStrobe | output | 1 | One-cycle strobe: a selected transaction ended with STOP |

## Verification
The assertions assume that SDA changes only while SCL is low, except for START and STOP. They also assume SCL stays low or high for several system clocks, so a synchronised edge is never missed and `execBusy` is stable when the address byte completes. The bench's bit-level tasks hold each SCL quarter period for four clocks and move SDA only in the low phase. It makes the line changes that form START and STOP only on purpose. Step mode is closed with a normal STOP, whose clock pulse counts as one more down step.

// File: rtl/potbus_pkg.sv
package potbus_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD_BYTE, ST_RD_ACK, ST_STEP, ST_WAIT_STOP
  } frameState_t;

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_XFER, OP_STEP} opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic releaseSda;
  } dpCtl_t;

  // bus events from datapath to control
  typedef struct packed {
    logic              startEv;
    logic              stopEv;
    logic              sclRise;
    logic              sclFall;
    logic              sdaBit;
    logic              byteFull;
    logic [BYTE_W-1:0] rxByte;
  } dpEvt_t;

  function automatic opClass_t classifyOp(input logic [3:0] op);
    case (op)
      4'b1001, 4'b1011:                   return OP_READ;
      4'b1010, 4'b1100:                   return OP_WRITE;
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return OP_XFER;
      4'b0010:                            return OP_STEP;
      default:                            return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/potbus_sync.sv
module potbus_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/potbus_dp.sv
module potbus_dp
  import potbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] txData,
  output dpEvt_t            evt,
  output logic              sdaPullLow
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines, syncLines;
  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    potbus_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLines[g]),
      .dout(syncLines[g])
    );
  end

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = syncLines[1];
  assign sdaNow = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              sdaLowR;

  assign evt.sclRise  = sclNow & ~sclPrev;
  assign evt.sclFall  = ~sclNow & sclPrev;
  assign evt.startEv  = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evt.stopEv   = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign evt.sdaBit   = sdaNow;
  assign evt.byteFull = (bitCnt == BIT_W'(BYTE_W));
  assign evt.rxByte   = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (ctl.clrBits)                      bitCnt <= '0;
      else if (evt.sclRise && !evt.byteFull) bitCnt <= bitCnt + 1'b1;
      if (evt.sclRise) rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaLowR <= 1'b0;
    end else if (ctl.releaseSda) begin
      sdaLowR <= 1'b0;
    end else if (ctl.driveAck) begin
      sdaLowR <= 1'b1;
    end else if (ctl.loadTx) begin
      txShift <= txData;
      sdaLowR <= ~txData[BYTE_W-1];
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
      sdaLowR <= ~txShift[BYTE_W-2];
    end
  end

  assign sdaPullLow = sdaLowR;

  // the line is only ever pulled down in the SCL low phase
  assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowR) |-> $past(evt.sclFall));
endmodule

// File: rtl/potbus_ctrl.sv
module potbus_ctrl
  import potbus_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpEvt_t            evt,
  input  logic              sdaPullLow,
  input  logic [3:0]        devAddr,
  input  logic              execBusy,
  input  logic [BYTE_W-1:0] rdData,
  output dpCtl_t            ctl,
  output logic [BYTE_W-1:0] txData,
  output logic              cmdValid,
  output logic [3:0]        cmdOp,
  output logic              cmdPot,
  output logic [1:0]        cmdReg,
  output logic [BYTE_W-1:0] cmdData,
  output logic              stepValid,
  output logic              stepUp,
  output logic              stopStrobe
);
  frameState_t state, nextState;
  logic fireCmd, fireStep, fireStop, latchInstr, latchData, masterAck;
  logic selected;

  assign selected = !(state inside {ST_IDLE, ST_ADDR});
  assign txData   = rdData;

  always_comb begin
    ctl        = '0;
    nextState  = state;
    fireCmd    = 1'b0;
    fireStep   = 1'b0;
    fireStop   = 1'b0;
    latchInstr = 1'b0;
    latchData  = 1'b0;
    if (evt.startEv) begin
      nextState      = ST_ADDR;
      ctl.clrBits    = 1'b1;
      ctl.releaseSda = 1'b1;
    end else if (evt.stopEv) begin
      nextState      = ST_IDLE;
      ctl.releaseSda = 1'b1;
      fireStop       = selected;
    end else begin
      case (state)
        ST_ADDR: if (evt.sclFall && evt.byteFull) begin
          if (evt.rxByte == {DEV_ID, devAddr} && !execBusy) begin
            nextState    = ST_ADDR_ACK;
            ctl.driveAck = 1'b1;
          end else begin
            nextState    = ST_IDLE;
          end
        end
        ST_ADDR_ACK: if (evt.sclFall) begin
          ctl.releaseSda = 1'b1;
          ctl.clrBits    = 1'b1;
          nextState      = ST_INSTR;
        end
        ST_INSTR: if (evt.sclFall && evt.byteFull) begin
          ctl.driveAck = 1'b1;
          latchInstr   = 1'b1;
          nextState    = ST_INSTR_ACK;
        end
        ST_INSTR_ACK: if (evt.sclFall) begin
          case (classifyOp(cmdOp))
            OP_READ: begin
              ctl.loadTx  = 1'b1;
              ctl.clrBits = 1'b1;
              nextState   = ST_RD_BYTE;
            end
            OP_WRITE: begin
              ctl.releaseSda = 1'b1;
              ctl.clrBits    = 1'b1;
              nextState      = ST_DATA;
            end
            OP_XFER: begin
              ctl.releaseSda = 1'b1;
              fireCmd        = 1'b1;
              nextState      = ST_WAIT_STOP;
            end
            OP_STEP: begin
              ctl.releaseSda = 1'b1;
              nextState      = ST_STEP;
            end
            default: begin
              ctl.releaseSda = 1'b1;
              nextState      = ST_WAIT_STOP;
            end
          endcase
        end
        ST_DATA: if (evt.sclFall && evt.byteFull) begin
          ctl.driveAck = 1'b1;
          latchData    = 1'b1;
          fireCmd      = 1'b1;
          nextState    = ST_DATA_ACK;
        end
        ST_DATA_ACK: if (evt.sclFall) begin
          ctl.releaseSda = 1'b1;
          nextState      = ST_WAIT_STOP;
        end
        ST_RD_BYTE: if (evt.sclFall) begin
          if (evt.byteFull) begin
            ctl.releaseSda = 1'b1;
            nextState      = ST_RD_ACK;
          end else begin
            ctl.shiftTx    = 1'b1;
          end
        end
        ST_RD_ACK: if (evt.sclFall) begin
          if (masterAck) begin
            ctl.loadTx  = 1'b1;
            ctl.clrBits = 1'b1;
            nextState   = ST_RD_BYTE;
          end else begin
            nextState   = ST_WAIT_STOP;
          end
        end
        ST_STEP: if (evt.sclRise) fireStep = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      masterAck  <= 1'b0;
      cmdValid   <= 1'b0;
      cmdOp      <= '0;
      cmdPot     <= 1'b0;
      cmdReg     <= '0;
      cmdData    <= '0;
      stepValid  <= 1'b0;
      stepUp     <= 1'b0;
      stopStrobe <= 1'b0;
    end else begin
      state      <= nextState;
      cmdValid   <= fireCmd;
      stepValid  <= fireStep;
      stopStrobe <= fireStop;
      if (state == ST_RD_ACK && evt.sclRise) masterAck <= ~evt.sdaBit;
      if (fireStep) stepUp <= evt.sdaBit;
      if (latchInstr) begin
        cmdOp  <= evt.rxByte[7:4];
        cmdPot <= evt.rxByte[2];
        cmdReg <= evt.rxByte[1:0];
      end
      if (latchData) cmdData <= evt.rxByte;
    end
  end

  assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && evt.sclFall && evt.byteFull && execBusy) |=> !sdaPullLow);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopEv |=> (!sdaPullLow && state == ST_IDLE));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, stepValid, stopStrobe}));

  assert_step_in_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> $past(state == ST_STEP));

  assert_cmd_kind_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (classifyOp(cmdOp) inside {OP_WRITE, OP_XFER}));
endmodule

// File: rtl/potbus_framer.sv
module potbus_framer
  import potbus_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [3:0] devAddr,
  input  logic       execBusy,
  input  logic [7:0] rdData,
  output logic       sdaPullLow,
  output logic       cmdValid,
  output logic [3:0] cmdOp,
  output logic       cmdPot,
  output logic [1:0] cmdReg,
  output logic [7:0] cmdData,
  output logic       stepValid,
  output logic       stepUp,
  output logic       stopStrobe
);
  dpCtl_t            ctl;
  dpEvt_t            evt;
  logic [BYTE_W-1:0] txData;

  potbus_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .txData    (txData),
    .evt       (evt),
    .sdaPullLow(sdaPullLow)
  );

  potbus_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .sdaPullLow(sdaPullLow),
    .devAddr   (devAddr),
    .execBusy  (execBusy),
    .rdData    (rdData),
    .ctl       (ctl),
    .txData    (txData),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdPot    (cmdPot),
    .cmdReg    (cmdReg),
    .cmdData   (cmdData),
    .stepValid (stepValid),
    .stepUp    (stepUp),
    .stopStrobe(stopStrobe)
  );
endmodule

// File: tb/potbus_framer_bench.sv
module potbus_framer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, busy = 1'b0;
  logic [3:0] devAddr = 4'hA;
  logic [7:0] rdData;
  logic sdaLine, sdaPullLow, cmdValid, cmdPot, stepValid, stepUp, stopStrobe;
  logic [3:0] cmdOp;
  logic [1:0] cmdReg;
  logic [7:0] cmdData;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;
  assign rdData  = cmdPot ? 8'h3C : 8'hC3;

  potbus_framer u_potbus_framer (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .devAddr(devAddr),
    .execBusy(busy), .rdData(rdData), .sdaPullLow(sdaPullLow), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdPot(cmdPot), .cmdReg(cmdReg), .cmdData(cmdData),
    .stepValid(stepValid), .stepUp(stepUp), .stopStrobe(stopStrobe)
  );

  int nChecks = 0, nFails = 0;
  int cmdCnt = 0, stopCnt = 0, upCnt = 0, dnCnt = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (cmdValid) cmdCnt++;
    if (stopStrobe) stopCnt++;
    if (stepValid && stepUp) upCnt++;
    if (stepValid && !stepUp) dnCnt++;
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); acked = ~sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(output logic [7:0] v, input logic giveAck);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); v[i] = sdaLine; waitQ(); sclM = 1'b0; waitQ();
    end
    sendBit(~giveAck);
    sdaM = 1'b1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // {addr, instr, data, busy, expAddrAck, expCmd, expDataAck}; devAddr = A
  localparam int NVEC = 11;
  localparam logic [27:0] VEC [NVEC] = '{
    28'h5AA42D7,  // write wiper, pot 1
    28'h5BA42D0,  // strap nibble mismatch
    28'h4AA42D0,  // identifier nibble mismatch
    28'h5AA42D8,  // executor busy: no ACK
    28'h5AC3157,  // write stored register, pot 0 reg 3
    28'h5AD6776,  // transfer, pot 1 reg 2
    28'h5A13776,  // global transfer
    28'h5A50774,  // unknown opcode
    28'h5AE1776,  // transfer wiper to store
    28'h5A80776,  // global transfer wiper to store
    28'h5AAB3F7   // write wiper, bit 3 set, pot 0 reg 3
  };

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic [7:0] aB, iB, dB, rv;
    logic bz, eA, eC, eD, ack1, ack2, ack3;
    int c0, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    // R1: reset state
    check("R1 pull-down", sdaPullLow, 0);
    check("R1 strobes", cmdCnt + stopCnt + upCnt + dnCnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      {aB, iB, dB, bz, eA, eC, eD} = VEC[v];
      c0 = cmdCnt; s0 = stopCnt;
      busy = bz;
      busStart();
      sendByte(aB, ack1);
      busy = 1'b0;
      check("R2/R3 address ack", ack1, eA);
      sendByte(iB, ack2);
      check("R2/R10 instruction ack", ack2, eA);
      sendByte(dB, ack3);
      check("R4/R5/R10 data ack", ack3, eD);
      busStop();
      waitQ();
      check("R4/R5/R10 command count", cmdCnt - c0, eC);
      check("R8 stop strobe", stopCnt - s0, eA);
      if (eC) begin
        check("R4/R5 opcode", cmdOp, iB[7:4]);
        check("R4/R5 pot", cmdPot, iB[2]);
        check("R4/R5 reg", cmdReg, iB[1:0]);
      end
      if (eD) check("R4 data", cmdData, dB);
    end

    // R6: read wiper of pot 1 (rdData 3C), two bytes, then NACK
    c0 = cmdCnt; s0 = stopCnt;
    busStart();
    sendByte(8'h5A, ack1); sendByte(8'h94, ack2);
    check("R6 instruction ack", ack1 & ack2, 1);
    readByte(rv, 1'b1); check("R6 first byte", rv, 8'h3C);
    readByte(rv, 1'b0); check("R6 byte after master ack", rv, 8'h3C);
    readByte(rv, 1'b0); check("R6 released after nack", rv, 8'hFF);
    busStop(); waitQ();
    check("R6 no command strobe", cmdCnt - c0, 0);
    check("R8 stop after read", stopCnt - s0, 1);

    // R6: read stored register of pot 0 (rdData C3)
    busStart();
    sendByte(8'h5A, ack1); sendByte(8'hB2, ack2);
    readByte(rv, 1'b0); check("R6 pot0 byte", rv, 8'hC3);
    busStop(); waitQ();

    // R7: step mode on pot 0, up, up, down; the STOP clock adds one down
    c0 = cmdCnt;
    busStart();
    sendByte(8'h5A, ack1); sendByte(8'h20, ack2);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    busStop(); waitQ();
    check("R7 up steps", upCnt, 2);
    check("R7 down steps", dnCnt, 2);
    check("R7 pot select", cmdPot, 0);
    check("R7 no command strobe", cmdCnt - c0, 0);

    // R9: repeated START in the middle of a data byte
    c0 = cmdCnt; s0 = stopCnt;
    busStart();
    sendByte(8'h5A, ack1); sendByte(8'hA4, ack2);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStart();
    sendByte(8'h5A, ack1); check("R9 address after restart", ack1, 1);
    sendByte(8'hA4, ack2); sendByte(8'h11, ack3);
    busStop(); waitQ();
    check("R9 single command", cmdCnt - c0, 1);
    check("R9 data from second frame", cmdData, 8'h11);
    check("R9 one stop", stopCnt - s0, 1);
    check("R1 released at end", sdaPullLow, 0);

    finishRun();
  end
endmodule